// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Mailbox

This block connects two processor sides, A and B, that share one clock. Each side has its own 32-bit register port and its own interrupt line. A side sends a word by writing one of its four transmit registers. The word then appears in the receive register with the same channel number on the opposite side. Hardware flags track whether each channel is occupied, so either side can work by polling or by interrupts.

Apart from data, each side can ring a doorbell on any of four channels. A doorbell raises a pending bit on the opposite side. The receiver acknowledges it by writing one to that pending bit, and the request bit on the sender then drops back to zero by itself. Each side also drives three plain flag bits, which the opposite side sees as read-only status bits. In every four-bit channel group, channel 0 sits at the most significant bit.

Top module: `ipc_mu`

## Requirements
- R1: Byte address map per side: transmit channel n at 0x00+4n (reads back the last word sent), receive channel n at 0x10+4n (read only; writes are ignored), status at 0x20, control at 0x24. All other addresses read 0.
- R2: A write to transmit channel n sets receive-full n (status bit 24+3-n) on the opposite side. It also clears transmit-empty n (status bit 20+3-n) on the writing side, from the following cycle on.
- R3: A read of receive channel n returns the word and clears receive-full n on the reading side. It also sets transmit-empty n back on the sending side.
- R4: Writing 1 to control bit 16+3-n rings doorbell n. This sets pending bit 28+3-n in the opposite side's status. Writing 0 there does nothing.
- R5: Writing 1 to a pending status bit clears it. Writing 0 leaves it set. Status writes change no other status bit.
- R6: Control bit 16+3-n reads 1 while doorbell n waits on the opposite side, and reads 0 once the opposite side has cleared it.
- R7: Control bits [2:0] of one side appear as status bits [2:0] of the opposite side.
- R8: A side's interrupt is high exactly when a status flag is set together with its matching enable. The pairs are: pending with control bit 28+3-n, receive-full with 24+3-n, and transmit-empty with 20+3-n.
- R9: After reset, status reads 0x00F00000 (all transmit-empty set, bit 9 zero), control reads 0, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Side A register write strobe |
| a_rd_en | input | 1 | Side A register read strobe (side effects on receive reads) |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational from a_addr |
| a_irq | output | 1 | Side A interrupt |
| b_wr_en | input | 1 | Side B register write strobe |
| b_rd_en | input | 1 | Side B register read strobe |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational from b_addr |
| b_irq | output | 1 | Side B interrupt |

## Verification
A wrong occupancy or doorbell bit shows at the ports in the cycle right after the write or read that caused it. Both sides' status words expose that state as directly readable bits, so a read issued one cycle later sees the error. Because the interrupt is combinational from those same bits, a stale flag also turns into a wrong interrupt level at once. A mirrored channel order or a misplaced field shows up as a wrong bit in a status word whose every bit is predicted. The stimulus mixes all four channel positions, both transfer directions, acknowledge writes with zero and one, and writes to read-only fields.

// File: rtl/ipc_mu_pkg.sv
package ipc_mu_pkg;
  localparam int NCH    = 4;
  localparam int NFLAG  = 3;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 6;
  localparam int WIDX_W = ADDR_W - 2;
  localparam int CH_W   = $clog2(NCH);

  // field bases inside status / control words
  localparam int PEND_LSB  = 28;
  localparam int FULL_LSB  = 24;
  localparam int EMPTY_LSB = 20;
  localparam int REQ_LSB   = 16;

  // word indices
  localparam logic [WIDX_W-1:0] IDX_STAT = WIDX_W'(2 * NCH);
  localparam logic [WIDX_W-1:0] IDX_CTRL = WIDX_W'(2 * NCH + 1);

  typedef logic [NCH-1:0][REG_W-1:0] word_arr_t;

  // channel 0 lands on the highest bit of a group
  function automatic logic [NCH-1:0] swap_order(input logic [NCH-1:0] v);
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[NCH-1-i] = v[i];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] place_group(input logic [NCH-1:0] v, input int lsb);
    return REG_W'(swap_order(v)) << lsb;
  endfunction

  function automatic logic [NCH-1:0] pull_group(input logic [REG_W-1:0] w, input int lsb);
    return swap_order(w[lsb +: NCH]);
  endfunction
endpackage

// File: rtl/ipc_mu_lane.sv
// One transfer direction: data words, occupancy and doorbells.
module ipc_mu_lane
  import ipc_mu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   push,
  input  logic [REG_W-1:0] push_data,
  input  logic [NCH-1:0]   pop,
  input  logic [NCH-1:0]   ring,
  input  logic [NCH-1:0]   ack,
  output word_arr_t        data,
  output logic [NCH-1:0]   full,
  output logic [NCH-1:0]   pend
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data[c] <= '0;
        full[c] <= 1'b0;
        pend[c] <= 1'b0;
      end else begin
        if (push[c]) data[c] <= push_data;
        // a new word wins over a same-cycle read
        if (push[c])     full[c] <= 1'b1;
        else if (pop[c]) full[c] <= 1'b0;
        // a new ring wins over a same-cycle acknowledge
        if (ring[c])     pend[c] <= 1'b1;
        else if (ack[c]) pend[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipc_mu_side.sv
// Register front end of one side.
module ipc_mu_side
  import ipc_mu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq,
  output logic [NCH-1:0]    push,
  output logic [NCH-1:0]    pop,
  output logic [NCH-1:0]    ring,
  output logic [NCH-1:0]    ack,
  output logic [NFLAG-1:0]  flags_out,
  input  word_arr_t         out_data,
  input  logic [NCH-1:0]    out_full,
  input  logic [NCH-1:0]    out_pend,
  input  word_arr_t         in_data,
  input  logic [NCH-1:0]    in_full,
  input  logic [NCH-1:0]    in_pend,
  input  logic [NFLAG-1:0]  peer_flags
);
  logic              hit;
  logic [WIDX_W-1:0] widx;
  logic              stat_wr, ctrl_wr;
  logic [NCH-1:0]    gie, rie, tie;
  logic [NFLAG-1:0]  flags_q;
  logic [REG_W-1:0]  status_word, ctrl_word;

  assign hit     = (addr[1:0] == 2'b00);
  assign widx    = addr[ADDR_W-1:2];
  assign stat_wr = wr_en && hit && (widx == IDX_STAT);
  assign ctrl_wr = wr_en && hit && (widx == IDX_CTRL);

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign push[c] = wr_en && hit && (widx == WIDX_W'(c));
    assign pop[c]  = rd_en && hit && (widx == WIDX_W'(NCH + c));
  end

  assign ring = ctrl_wr ? pull_group(wdata, REQ_LSB)  : '0;
  assign ack  = stat_wr ? pull_group(wdata, PEND_LSB) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie     <= '0;
      rie     <= '0;
      tie     <= '0;
      flags_q <= '0;
    end else if (ctrl_wr) begin
      gie     <= pull_group(wdata, PEND_LSB);
      rie     <= pull_group(wdata, FULL_LSB);
      tie     <= pull_group(wdata, EMPTY_LSB);
      flags_q <= wdata[NFLAG-1:0];
    end
  end

  assign flags_out = flags_q;

  assign status_word = place_group(in_pend, PEND_LSB)
                     | place_group(in_full, FULL_LSB)
                     | place_group(~out_full, EMPTY_LSB)
                     | REG_W'(peer_flags);

  assign ctrl_word = place_group(gie, PEND_LSB)
                   | place_group(rie, FULL_LSB)
                   | place_group(tie, EMPTY_LSB)
                   | place_group(out_pend, REQ_LSB)
                   | REG_W'(flags_q);

  assign irq = |(in_pend & gie) | |(in_full & rie) | |(~out_full & tie);

  always_comb begin
    rdata = '0;
    if (hit) begin
      if (widx < WIDX_W'(NCH))            rdata = out_data[widx[CH_W-1:0]];
      else if (widx < WIDX_W'(2 * NCH))   rdata = in_data[widx[CH_W-1:0]];
      else if (widx == IDX_STAT)          rdata = status_word;
      else if (widx == IDX_CTRL)          rdata = ctrl_word;
    end
  end
endmodule

// File: rtl/ipc_mu.sv
module ipc_mu
  import ipc_mu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr_en,
  input  logic              a_rd_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [REG_W-1:0]  a_wdata,
  output logic [REG_W-1:0]  a_rdata,
  output logic              a_irq,
  input  logic              b_wr_en,
  input  logic              b_rd_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [REG_W-1:0]  b_wdata,
  output logic [REG_W-1:0]  b_rdata,
  output logic              b_irq
);
  // named internal events, visible to the bound checker
  logic [NCH-1:0]   a_tx_wr, b_tx_wr, a_rx_rd, b_rx_rd;
  logic [NCH-1:0]   a_ring, b_ring, a_ack, b_ack;
  logic [NCH-1:0]   ab_full, ba_full, ab_pend, ba_pend;
  word_arr_t        ab_data, ba_data;
  logic [NFLAG-1:0] a_flags, b_flags;

  ipc_mu_lane u_lane_ab (
    .clk, .rst_n,
    .push(a_tx_wr), .push_data(a_wdata), .pop(b_rx_rd),
    .ring(a_ring), .ack(b_ack),
    .data(ab_data), .full(ab_full), .pend(ab_pend)
  );

  ipc_mu_lane u_lane_ba (
    .clk, .rst_n,
    .push(b_tx_wr), .push_data(b_wdata), .pop(a_rx_rd),
    .ring(b_ring), .ack(a_ack),
    .data(ba_data), .full(ba_full), .pend(ba_pend)
  );

  ipc_mu_side u_side_a (
    .clk, .rst_n,
    .wr_en(a_wr_en), .rd_en(a_rd_en), .addr(a_addr), .wdata(a_wdata),
    .rdata(a_rdata), .irq(a_irq),
    .push(a_tx_wr), .pop(a_rx_rd), .ring(a_ring), .ack(a_ack), .flags_out(a_flags),
    .out_data(ab_data), .out_full(ab_full), .out_pend(ab_pend),
    .in_data(ba_data), .in_full(ba_full), .in_pend(ba_pend), .peer_flags(b_flags)
  );

  ipc_mu_side u_side_b (
    .clk, .rst_n,
    .wr_en(b_wr_en), .rd_en(b_rd_en), .addr(b_addr), .wdata(b_wdata),
    .rdata(b_rdata), .irq(b_irq),
    .push(b_tx_wr), .pop(b_rx_rd), .ring(b_ring), .ack(b_ack), .flags_out(b_flags),
    .out_data(ba_data), .out_full(ba_full), .out_pend(ba_pend),
    .in_data(ab_data), .in_full(ab_full), .in_pend(ab_pend), .peer_flags(a_flags)
  );
endmodule

// File: rtl/ipc_mu_chk.sv
module ipc_mu_chk
  import ipc_mu_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] a_tx_wr,
  input logic [NCH-1:0] b_rx_rd,
  input logic [NCH-1:0] a_ring,
  input logic [NCH-1:0] b_ack,
  input logic [NCH-1:0] ab_full,
  input logic [NCH-1:0] ba_full,
  input logic [NCH-1:0] ab_pend,
  input logic [NCH-1:0] ba_pend
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (ab_full == '0 && ba_full == '0 && ab_pend == '0 && ba_pend == '0));

  assert_tx_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && a_tx_wr != '0) |=> ((ab_full & $past(a_tx_wr)) == $past(a_tx_wr)));

  assert_rx_clears_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (b_rx_rd & ~a_tx_wr) != '0) |=> ((ab_full & $past(b_rx_rd & ~a_tx_wr)) == '0));

  assert_ring_sets_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && a_ring != '0) |=> ((ab_pend & $past(a_ring)) == $past(a_ring)));

  assert_ack_clears_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (b_ack & ~a_ring) != '0) |=> ((ab_pend & $past(b_ack & ~a_ring)) == '0));

  assert_no_spurious_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> ((ab_pend & ~$past(ab_pend) & ~$past(a_ring)) == '0));
endmodule

bind ipc_mu ipc_mu_chk u_ipc_mu_chk (.*);

// File: tb/test_ipc_mu.sv
`timescale 1ns/1ps
module test_ipc_mu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_wr_en = 1'b0, a_rd_en = 1'b0, b_wr_en = 1'b0, b_rd_en = 1'b0;
  logic [5:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;
  int          errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  ipc_mu i_ipc_mu (.*);

  typedef struct packed {
    logic        side;  // 0 = A, 1 = B
    logic        wr;    // 1 = write, 0 = read and compare
    logic [5:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [0:NV-1] = '{
    '{1'b1, 1'b0, 6'h20, 32'h0, 32'h00F00000, 8'd9},   // R9 status after reset
    '{1'b0, 1'b0, 6'h24, 32'h0, 32'h00000000, 8'd9},   // R9 control after reset
    '{1'b0, 1'b1, 6'h00, 32'hCAFE0001, 32'h0, 8'd2},   // R2 A sends ch0
    '{1'b1, 1'b0, 6'h20, 32'h0, 32'h08F00000, 8'd2},   // R2 B full ch0 (bit 27)
    '{1'b0, 1'b0, 6'h20, 32'h0, 32'h00700000, 8'd2},   // R2 A empty ch0 cleared
    '{1'b1, 1'b0, 6'h10, 32'h0, 32'hCAFE0001, 8'd1},   // R1 B receives ch0
    '{1'b1, 1'b0, 6'h20, 32'h0, 32'h00F00000, 8'd3},   // R3 full cleared
    '{1'b0, 1'b0, 6'h20, 32'h0, 32'h00F00000, 8'd3},   // R3 empty restored
    '{1'b1, 1'b1, 6'h0C, 32'h12345678, 32'h0, 8'd2},   // R2 B sends ch3
    '{1'b0, 1'b0, 6'h20, 32'h0, 32'h01F00000, 8'd2},   // R2 A full ch3 (bit 24)
    '{1'b1, 1'b0, 6'h20, 32'h0, 32'h00E00000, 8'd2},   // R2 B empty ch3 (bit 20) cleared
    '{1'b1, 1'b0, 6'h0C, 32'h0, 32'h12345678, 8'd1},   // R1 transmit readback
    '{1'b0, 1'b0, 6'h1C, 32'h0, 32'h12345678, 8'd1},   // R1 A receives ch3
    '{1'b1, 1'b0, 6'h20, 32'h0, 32'h00F00000, 8'd3},   // R3 sender empty again
    '{1'b0, 1'b1, 6'h24, 32'h00040000, 32'h0, 8'd4},   // R4 A rings ch1 (bit 18)
    '{1'b1, 1'b0, 6'h20, 32'h0, 32'h40F00000, 8'd4},   // R4 B pending ch1 (bit 30)
    '{1'b0, 1'b0, 6'h24, 32'h0, 32'h00040000, 8'd6},   // R6 request visible
    '{1'b1, 1'b1, 6'h20, 32'h40000000, 32'h0, 8'd5},   // R5 B acknowledges
    '{1'b1, 1'b0, 6'h20, 32'h0, 32'h00F00000, 8'd5},   // R5 pending cleared
    '{1'b0, 1'b0, 6'h24, 32'h0, 32'h00000000, 8'd6},   // R6 request dropped
    '{1'b0, 1'b1, 6'h24, 32'h00000005, 32'h0, 8'd7},   // R7 A sets flags
    '{1'b1, 1'b0, 6'h20, 32'h0, 32'h00F00005, 8'd7},   // R7 B sees flags
    '{1'b0, 1'b0, 6'h24, 32'h0, 32'h00000005, 8'd7},   // R7 flags readback
    '{1'b1, 1'b1, 6'h20, 32'hFFFFFFFF, 32'h0, 8'd5},   // R5 status write, nothing pending
    '{1'b1, 1'b0, 6'h20, 32'h0, 32'h00F00005, 8'd5},   // R5 status unchanged
    '{1'b0, 1'b1, 6'h14, 32'hDEAD0000, 32'h0, 8'd1},   // R1 write to receive reg
    '{1'b0, 1'b0, 6'h14, 32'h0, 32'h00000000, 8'd1},   // R1 receive reg unchanged
    '{1'b1, 1'b0, 6'h20, 32'h0, 32'h00F00005, 8'd1}    // R1 no transfer started
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic side, input logic wr, input logic [5:0] addr,
                       input logic [31:0] data, output logic [31:0] rd);
    @(negedge clk);
    if (!side) begin
      a_addr = addr; a_wdata = data; a_wr_en = wr; a_rd_en = !wr;
    end else begin
      b_addr = addr; b_wdata = data; b_wr_en = wr; b_rd_en = !wr;
    end
    #1 rd = side ? b_rdata : a_rdata;
    @(posedge clk);
    #1;
    a_wr_en = 1'b0; a_rd_en = 1'b0; b_wr_en = 1'b0; b_rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R9 a_irq after reset", {31'b0, a_irq}, 32'h0);
    check("R9 b_irq after reset", {31'b0, b_irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_op(TBL[i].side, TBL[i].wr, TBL[i].addr, TBL[i].data, rd);
      if (!TBL[i].wr)
        check($sformatf("R%0d vector %0d", TBL[i].req, i), rd, TBL[i].exp);
    end

    // R8 receive interrupt on ch2 (enable bit 25)
    do_op(1'b0, 1'b1, 6'h24, 32'h02000005, rd);
    check("R8 a_irq idle with rx enable", {31'b0, a_irq}, 32'h0);
    do_op(1'b1, 1'b1, 6'h08, 32'h0000BEEF, rd);
    check("R8 a_irq on rx full ch2", {31'b0, a_irq}, 32'h1);
    do_op(1'b0, 1'b0, 6'h18, 32'h0, rd);
    check("R1 A receives ch2", rd, 32'h0000BEEF);
    check("R8 a_irq after receive read", {31'b0, a_irq}, 32'h0);

    // R8 transmit-empty interrupt
    do_op(1'b1, 1'b1, 6'h24, 32'h00F00000, rd);
    check("R8 b_irq on tx empty enable", {31'b0, b_irq}, 32'h1);
    do_op(1'b1, 1'b1, 6'h24, 32'h00000000, rd);
    check("R8 b_irq tx enable removed", {31'b0, b_irq}, 32'h0);

    // R8 / R5 / R6 doorbell interrupt on ch0
    do_op(1'b1, 1'b1, 6'h24, 32'h80000000, rd);
    check("R8 b_irq gp enable only", {31'b0, b_irq}, 32'h0);
    do_op(1'b0, 1'b1, 6'h24, 32'h00080005, rd);
    check("R8 b_irq on doorbell ch0", {31'b0, b_irq}, 32'h1);
    do_op(1'b1, 1'b1, 6'h20, 32'h00000000, rd);
    do_op(1'b1, 1'b0, 6'h20, 32'h0, rd);
    check("R5 zero write keeps pending", rd, 32'h80F00005);
    check("R5 b_irq still high", {31'b0, b_irq}, 32'h1);
    do_op(1'b0, 1'b0, 6'h24, 32'h0, rd);
    check("R6 request held", rd, 32'h00080005);
    do_op(1'b1, 1'b1, 6'h20, 32'h80000000, rd);
    check("R8 b_irq after acknowledge", {31'b0, b_irq}, 32'h0);
    do_op(1'b0, 1'b0, 6'h24, 32'h0, rd);
    check("R6 request cleared", rd, 32'h00000005);

    // R4 writing zero to request bits rings nothing
    do_op(1'b0, 1'b1, 6'h24, 32'h00000005, rd);
    do_op(1'b1, 1'b0, 6'h20, 32'h0, rd);
    check("R4 zero request no ring", rd, 32'h00F00005);

    // R8 masked receive flag (A receive enables now 0)
    do_op(1'b1, 1'b1, 6'h04, 32'h00000011, rd);
    check("R8 a_irq masked rx full", {31'b0, a_irq}, 32'h0);
    do_op(1'b0, 1'b0, 6'h20, 32'h0, rd);
    check("R2 A full ch1 (bit 26)", rd, 32'h04F00000);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule